// File: doc/BRIEF.md
# Manchester Edge-Interval Receiver

This block recovers bytes from a single Manchester-coded serial line. It does not sample a bit clock. It measures the number of timebase ticks between successive transitions of the line, and a `tick_en` strobe supplies that timebase (nominally 1 MHz). Each measured interval is sorted as short (about half a bit period) or long (about one bit period). The bits are then rebuilt from this interval sequence alone. A pending half-bit flag and the last decoded bit value carry the state needed to do it. The direction of a mid-bit transition is never consulted.

A frame starts with an alternating preamble byte, which on the line has transitions only at mid-bit. The block counts a fixed number of evenly spaced preamble transitions to lock on. It then packs the decoded bits, most significant bit first, into an internal byte buffer. A byte of all ones closes the frame and raises a done flag. While done is set, further traffic on the line is ignored. A host reads the byte count and the buffered bytes through an addressed read port, then pulses an acknowledge to clear done and re-arm the receiver.

Any timing violation, a full buffer, or an interval that outlasts the counter sends the decoder back to idle without raising done. The line is sampled by the block and cannot be paused, so there is no back-pressure on the input. The read port is a plain addressed read with a fixed one-cycle latency and no handshake.

Top module: `mdec_rx`

## Requirements
- R1: In the idle state, a rising edge of the synchronised line starts preamble tracking only while done is clear. A falling edge, or any edge while done is set, leaves the block idle, so a frame sent while done is set changes neither the count nor the buffered bytes.
- R2: During preamble tracking, every interval must lie within 200 to 300 ticks inclusive, or the block returns to idle. The starting edge counts as 1. When the count reaches 8, data decoding begins with the previous bit at 0, the pending flag clear and the byte count at 0.
- R3: During data decoding, an interval of 75 to 175 ticks is short and one of 200 to 300 ticks is long. Any other interval returns the block to idle.
- R4: A short interval with pending clear sets pending and yields no bit. A short interval with pending set yields the previous bit value again and clears pending.
- R5: A long interval with pending set is an error and returns the block to idle. A long interval with pending clear inverts the previous bit and yields the new value.
- R6: Yielded bits are packed most significant bit first. The first bit of the n-th data byte lands in bit 7 of buffer entry n-1 (entry 0 holds the first byte after the preamble).
- R7: A completed byte equal to 8'hFF ends the frame. The byte is not stored or counted, `rx_done` goes high, `rx_count` equals the number of data bytes, and the block returns to idle.
- R8: If the buffer already holds BUF_BYTES bytes when a bit is yielded, the block returns to idle with `rx_done` low.
- R9: If the interval counter reaches its all-ones value without an edge, that value is taken as the interval, and the block returns to idle from preamble tracking or data decoding.
- R10: An interval is the number of `tick_en` pulses between two detected edges. The counter restarts at every edge, and the edge direction is the synchronised line level after the edge.
- R11: `rd_data` shows buffer entry `rd_addr` one clock after `rd_addr` is applied. `rx_done` and `rx_count` are 0 after reset. `rx_done` stays high until `rd_ack` is pulsed, and clears on the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase strobe; one pulse per interval tick |
| line_in | input | 1 | Asynchronous Manchester-coded line |
| rx_done | output | 1 | Frame complete; buffer holds valid data |
| rx_count | output | $clog2(BUF_BYTES*8+1)-3 | Number of data bytes in the buffer |
| rd_addr | input | $clog2(BUF_BYTES) | Buffer entry to read |
| rd_ack | input | 1 | One-cycle pulse that clears done |
| rd_data | output | 8 | Buffer entry selected one cycle earlier |

## Verification
The assertions assume three things about the inputs. Line transitions are spaced well beyond the synchroniser depth, so every transition produces exactly one edge event. `rd_ack` is used only to release a finished frame. `tick_en` is the only time reference, so every interval is measured in its pulses. The bench holds `tick_en` high and generates every half-bit with a seeded random jitter of at most 8 ticks around 125. This keeps legal short and long intervals inside their windows, and only the directed error cases step outside them. The bench shrinks the counter width and buffer depth through parameters, so that overflow and buffer-full cases are reached within a short run.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;

  localparam logic [7:0] END_MARK = 8'hFF;

  // inclusive window test on an interval length
  function automatic logic in_window(input int unsigned len,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (len >= lo) && (len <= hi);
  endfunction

endpackage

// File: rtl/mdec_edge_sync.sv
module mdec_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic edge_o,
  output logic level_o
);

  logic [STAGES-1:0] chain;
  logic              last_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain    <= '0;
      last_lvl <= 1'b0;
    end else begin
      chain    <= {chain[STAGES-2:0], line_i};
      last_lvl <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign edge_o  = chain[STAGES-1] ^ last_lvl;

endmodule

// File: rtl/mdec_interval.sv
module mdec_interval #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic             level_i,
  output logic             evt_valid_o,
  output logic             evt_edge_o,
  output logic             evt_rise_o,
  output logic [CNT_W-1:0] evt_len_o
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap        = tick_i && (cnt == '1) && !edge_i;
  assign evt_valid_o = edge_i || wrap;
  assign evt_edge_o  = edge_i;
  assign evt_rise_o  = edge_i && level_i;
  assign evt_len_o   = edge_i ? cnt : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (edge_i) begin
      cnt <= tick_i ? CNT_W'(1) : '0;
    end else if (wrap) begin
      cnt <= '0;
    end else if (tick_i) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mdec_fsm.sv
module mdec_fsm
  import mdec_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRE_COUNT = 8,
  parameter int SHORT_MIN = 75,
  parameter int SHORT_MAX = 175,
  parameter int LONG_MIN  = 200,
  parameter int LONG_MAX  = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid_i,
  input  logic             evt_edge_i,
  input  logic             evt_rise_i,
  input  logic [CNT_W-1:0] evt_len_i,
  input  logic             pk_full_i,
  input  logic             pk_mark_i,
  input  logic             ack_i,
  output rx_state_e        state_o,
  output logic             start_o,
  output logic             emit_o,
  output logic             bit_o,
  output logic             done_o
);

  localparam int PC_W = $clog2(PRE_COUNT + 1);

  rx_state_e        st, st_n;
  logic [PC_W-1:0]  pc, pc_n;
  logic             pend, pend_n;
  logic             prev, prev_n;
  logic             done, done_n;
  logic             is_short, is_long;

  assign is_short = in_window(int'(evt_len_i), SHORT_MIN, SHORT_MAX);
  assign is_long  = in_window(int'(evt_len_i), LONG_MIN, LONG_MAX);

  always_comb begin
    st_n    = st;
    pc_n    = pc;
    pend_n  = pend;
    prev_n  = prev;
    done_n  = done;
    start_o = 1'b0;
    emit_o  = 1'b0;
    bit_o   = prev;
    if (ack_i) done_n = 1'b0;
    if (evt_valid_i) begin
      unique case (st)
        ST_IDLE: begin
          if (evt_edge_i && evt_rise_i && !done) begin
            st_n = ST_SYNC;
            pc_n = PC_W'(1);
          end
        end
        ST_SYNC: begin
          if (!is_long) begin
            st_n = ST_IDLE;
          end else if (pc == PC_W'(PRE_COUNT - 1)) begin
            st_n    = ST_DATA;
            start_o = 1'b1;
            pend_n  = 1'b0;
            prev_n  = 1'b0;
          end else begin
            pc_n = pc + PC_W'(1);
          end
        end
        ST_DATA: begin
          if (is_short) begin
            if (pend) begin
              pend_n = 1'b0;
              emit_o = 1'b1;
              bit_o  = prev;
            end else begin
              pend_n = 1'b1;
            end
          end else if (is_long) begin
            if (pend) begin
              st_n = ST_IDLE;
            end else begin
              prev_n = ~prev;
              emit_o = 1'b1;
              bit_o  = ~prev;
            end
          end else begin
            st_n = ST_IDLE;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
    // storage outcome of a yielded bit
    if (emit_o) begin
      if (pk_full_i) begin
        st_n = ST_IDLE;
      end else if (pk_mark_i && bit_o) begin
        done_n = 1'b1;
        st_n   = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pc   <= '0;
      pend <= 1'b0;
      prev <= 1'b0;
      done <= 1'b0;
    end else begin
      st   <= st_n;
      pc   <= pc_n;
      pend <= pend_n;
      prev <= prev_n;
      done <= done_n;
    end
  end

  assign state_o = st;
  assign done_o  = done;

endmodule

// File: rtl/mdec_packer.sv
module mdec_packer #(
  parameter int BUF_BYTES = 128,
  localparam int ADDR_W = $clog2(BUF_BYTES),
  localparam int BIT_W  = $clog2(BUF_BYTES * 8 + 1),
  localparam int HEAD_W = BIT_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              emit_i,
  input  logic              bit_i,
  output logic              full_o,
  output logic              mark_o,
  output logic [HEAD_W-1:0] count_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);

  localparam logic [HEAD_W-1:0] FULL_AT = HEAD_W'(BUF_BYTES);

  logic [BIT_W-1:0]  nbits;
  logic [6:0]        sh;
  logic [HEAD_W-1:0] head;
  logic              last_pos;
  logic              store;
  logic              closing;
  logic [7:0]        mem [BUF_BYTES];

  assign head     = nbits[BIT_W-1:3];
  assign last_pos = (nbits[2:0] == 3'd7);
  assign full_o   = (head == FULL_AT);
  assign mark_o   = last_pos && (&sh);
  assign store    = emit_i && !full_o;
  assign closing  = store && last_pos && bit_i && (&sh);
  assign count_o  = head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbits <= '0;
      sh    <= '0;
    end else if (start_i) begin
      nbits <= '0;
    end else if (store) begin
      sh <= {sh[5:0], bit_i};
      if (closing) nbits <= nbits - BIT_W'(7);
      else         nbits <= nbits + BIT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (store && last_pos && !closing) begin
      mem[head[ADDR_W-1:0]] <= {sh, bit_i};
    end
    rd_data_o <= mem[rd_addr_i];
  end

endmodule

// File: rtl/mdec_rx.sv
module mdec_rx
  import mdec_pkg::*;
#(
  parameter int BUF_BYTES   = 128,
  parameter int CNT_W       = 16,
  parameter int PRE_COUNT   = 8,
  parameter int SHORT_MIN   = 75,
  parameter int SHORT_MAX   = 175,
  parameter int LONG_MIN    = 200,
  parameter int LONG_MAX    = 300,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(BUF_BYTES),
  localparam int HEAD_W = $clog2(BUF_BYTES * 8 + 1) - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              line_in,
  output logic              rx_done,
  output logic [HEAD_W-1:0] rx_count,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  output logic [7:0]        rd_data
);

  logic             edge_det, lvl;
  logic             evt_valid, evt_edge, evt_rise;
  logic [CNT_W-1:0] evt_len;
  logic             pk_full, pk_mark;
  logic             start, emit, bit_val;
  rx_state_e        st;

  mdec_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (line_in),
    .edge_o  (edge_det),
    .level_o (lvl)
  );

  mdec_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_en),
    .edge_i      (edge_det),
    .level_i     (lvl),
    .evt_valid_o (evt_valid),
    .evt_edge_o  (evt_edge),
    .evt_rise_o  (evt_rise),
    .evt_len_o   (evt_len)
  );

  mdec_fsm #(
    .CNT_W     (CNT_W),
    .PRE_COUNT (PRE_COUNT),
    .SHORT_MIN (SHORT_MIN),
    .SHORT_MAX (SHORT_MAX),
    .LONG_MIN  (LONG_MIN),
    .LONG_MAX  (LONG_MAX)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid_i (evt_valid),
    .evt_edge_i  (evt_edge),
    .evt_rise_i  (evt_rise),
    .evt_len_i   (evt_len),
    .pk_full_i   (pk_full),
    .pk_mark_i   (pk_mark),
    .ack_i       (rd_ack),
    .state_o     (st),
    .start_o     (start),
    .emit_o      (emit),
    .bit_o       (bit_val),
    .done_o      (rx_done)
  );

  mdec_packer #(.BUF_BYTES(BUF_BYTES)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .emit_i    (emit),
    .bit_i     (bit_val),
    .full_o    (pk_full),
    .mark_o    (pk_mark),
    .count_o   (rx_count),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

endmodule

// File: rtl/mdec_rx_chk.sv
module mdec_rx_chk
  import mdec_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int CNT_W     = 16,
  parameter int HEAD_W    = 8,
  parameter int LONG_MIN  = 200,
  parameter int LONG_MAX  = 300
) (
  input logic              clk,
  input logic              rst_n,
  input rx_state_e         st,
  input logic              evt_valid,
  input logic              evt_edge,
  input logic              evt_rise,
  input logic [CNT_W-1:0]  evt_len,
  input logic              rx_done,
  input logic [HEAD_W-1:0] rx_count,
  input logic              rd_ack
);

  // R1
  idle_falling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && evt_valid && evt_edge && !evt_rise) |=> (st == ST_IDLE));

  // R1
  idle_while_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && rx_done) |=> (st == ST_IDLE));

  // R2
  sync_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SYNC && evt_valid &&
     (int'(evt_len) < LONG_MIN || int'(evt_len) > LONG_MAX)) |=> (st == ST_IDLE));

  // R7
  done_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> ($past(st) == ST_DATA && st == ST_IDLE));

  // R7
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> $stable(rx_count));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_count) <= BUF_BYTES);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rd_ack) |=> rx_done);

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rd_ack) |=> !rx_done);

endmodule

bind mdec_rx mdec_rx_chk #(
  .BUF_BYTES (BUF_BYTES),
  .CNT_W     (CNT_W),
  .HEAD_W    (HEAD_W),
  .LONG_MIN  (LONG_MIN),
  .LONG_MAX  (LONG_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st        (st),
  .evt_valid (evt_valid),
  .evt_edge  (evt_edge),
  .evt_rise  (evt_rise),
  .evt_len   (evt_len),
  .rx_done   (rx_done),
  .rx_count  (rx_count),
  .rd_ack    (rd_ack)
);

// File: tb/sim_mdec_rx.sv
module sim_mdec_rx;

  localparam int CLK_PERIOD = 10;
  localparam int BUFN       = 4;
  localparam int CW         = 12;
  localparam int HALF       = 125;
  localparam int QUIET      = 4600;
  localparam int WD_CYCLES  = 198000;
  localparam int AW         = $clog2(BUFN);
  localparam int HW         = $clog2(BUFN * 8 + 1) - 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b1;
  logic          line_in = 1'b0;
  logic          rd_ack = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          rx_done;
  logic [HW-1:0] rx_count;

  int   checks = 0;
  int   fails = 0;
  bit   finished = 1'b0;
  logic [7:0] fb [0:7];
  int   fn = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdec_rx #(.BUF_BYTES(BUFN), .CNT_W(CW)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .line_in  (line_in),
    .rx_done  (rx_done),
    .rx_count (rx_count),
    .rd_addr  (rd_addr),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // a frame completes only if its data fits the buffer
  function automatic bit exp_done(input int n);
    return n < BUFN;
  endfunction

  function automatic int jit();
    return HALF + int'($urandom_range(16)) - 8;
  endfunction

  task automatic hold(input logic lvl, input int d);
    line_in = lvl;
    repeat (d) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    hold(~b, jit());
    hold(b, jit());
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_frame();
    send_byte(8'hAA);
    for (int k = 0; k < fn; k++) send_byte(fb[k]);
    send_byte(8'hFF);
    hold(1'b1, 40);
    hold(1'b0, 400);
  endtask

  task automatic read_byte(input int a, output logic [7:0] d);
    rd_addr = AW'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic ack();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
    check("R11", "done after ack", int'(rx_done), 0);
  endtask

  task automatic verify_frame(input string req);
    logic [7:0] d;
    if (exp_done(fn)) begin
      check(req, "done (R7)", int'(rx_done), 1);
      check(req, "count (R7)", int'(rx_count), fn);
      for (int k = 0; k < fn; k++) begin
        read_byte(k, d);
        check(req, "byte (R6)", int'(d), int'(fb[k]));
      end
      ack();
    end else begin
      check("R8", "done with full buffer", int'(rx_done), 0);
      hold(1'b0, QUIET);
    end
  endtask

  task automatic random_bytes(input int n);
    fn = n;
    for (int k = 0; k < n; k++) fb[k] = 8'($urandom_range(254, 0));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (5) @(negedge clk);
    check("R11", "done in reset", int'(rx_done), 0);
    check("R11", "count in reset", int'(rx_count), 0);
    rst_n = 1'b1;
    hold(1'b0, 50);

    // directed patterns, R4 R5 R10
    fn = 3; fb[0] = 8'h00; fb[1] = 8'hFE; fb[2] = 8'h55;
    send_frame();
    verify_frame("R4");

    // random frames, R10
    for (int r = 0; r < 2; r++) begin
      random_bytes(int'($urandom_range(BUFN, 1)));
      send_frame();
      verify_frame("R10");
    end

    // frame while done set is ignored, R1
    fn = 2; fb[0] = 8'h12; fb[1] = 8'h34;
    send_frame();
    check("R1", "first frame done", int'(rx_done), 1);
    fn = 1; fb[0] = 8'h56;
    send_frame();
    begin
      logic [7:0] d;
      check("R1", "done kept", int'(rx_done), 1);
      check("R1", "count kept", int'(rx_count), 2);
      read_byte(0, d);
      check("R1", "byte kept", int'(d), 8'h12);
    end
    ack();

    // preamble interval out of window, R2
    hold(1'b1, 180);
    hold(1'b0, 300);
    check("R2", "done after bad preamble", int'(rx_done), 0);
    fn = 1; fb[0] = 8'hA5;
    send_frame();
    verify_frame("R2");

    // long interval while pending, R5
    send_byte(8'hAA);
    hold(1'b1, 2 * HALF);
    hold(1'b0, HALF);
    send_byte(8'h00);
    send_byte(8'hFF);
    hold(1'b1, 40);
    hold(1'b0, QUIET);
    check("R5", "done after pending error", int'(rx_done), 0);
    fn = 1; fb[0] = 8'h3C;
    send_frame();
    verify_frame("R5");

    // data interval between windows, R3
    send_byte(8'hAA);
    hold(1'b0, 60);
    hold(1'b1, HALF);
    send_byte(8'h00);
    send_byte(8'hFF);
    hold(1'b1, 40);
    hold(1'b0, QUIET);
    check("R3", "done after bad data interval", int'(rx_done), 0);
    fn = 1; fb[0] = 8'hC3;
    send_frame();
    verify_frame("R3");

    // counter overflow mid-frame, R9
    send_byte(8'hAA);
    send_byte(8'h3C);
    hold(1'b0, QUIET);
    check("R9", "done after silence", int'(rx_done), 0);
    fn = 2; fb[0] = 8'h81; fb[1] = 8'h7E;
    send_frame();
    verify_frame("R9");

    // buffer full, R8
    fn = BUFN;
    for (int k = 0; k < BUFN; k++) fb[k] = 8'(k + 1);
    send_frame();
    verify_frame("R8");

    // falling edge before preamble is ignored, R1
    hold(1'b1, QUIET);
    hold(1'b0, HALF);
    fn = 1; fb[0] = 8'h5A;
    send_frame();
    verify_frame("R1");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule